// File: doc/BRIEF.md
# SIMD Lane Extract Unit

This unit pulls one scalar element out of a 128-bit vector operand. An element-size select picks byte, doubleword or quadword granularity, and the low bits of an 8-bit immediate pick which lane of that size is taken. The element is then formatted for one of two destinations. For a general-purpose register, it is zero-extended. For a memory location, only the element is delivered, together with a byte count for the store.

The unit also performs the encoding checks that belong to this operation and raises an invalid-opcode flag when one fails. A quadword request is not allowed outside 64-bit mode. For the vector-encoded forms, the extra-register specifier must be all ones and the vector-length field must be zero.

Each request is accepted with an input valid strobe. The result is presented exactly one clock later with an output valid. The operation has no status-flag output.

Top module: `lane_extract_unit`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high and low otherwise. While `out_valid` is low, `reg_result`, `store_data`, `store_bytes` and `ud_flag` are all zero.
- R2: With `elem_sel`=0 (byte), the lane index is `imm[3:0]` and byte lane k is source bits [8k+7:8k], so lane 0 is bits [7:0]. For a register destination in 64-bit mode, `reg_result` holds the byte in [7:0] and zeros in [63:8].
- R3: With `elem_sel`=1 (doubleword) and no promotion, the lane index is `imm[1:0]`. The result is source bits [32k+31:32k], zero-extended.
- R4: In 64-bit mode (`mode64`=1), a quadword is extracted when `elem_sel`=2, or when `elem_sel`=1 with `w_bit`=1. The lane index is `imm[0]` and the result is source bits [64k+63:64k].
- R5: The byte form ignores `w_bit` in every mode. Outside 64-bit mode, `w_bit` is ignored for every form, so `elem_sel`=1 always yields a doubleword there.
- R6: Outside 64-bit mode, a register result is zero-filled from the top of the element up to bit 31, and bits [63:32] of `reg_result` are zero.
- R7: A request with `elem_sel`=2 while `mode64`=0 raises `ud_flag`.
- R8: When `vec_enc`=1, `ud_flag` is raised if `xreg_spec` is not 4'b1111 or if `vlen` is nonzero. When `vec_enc`=0, both fields are ignored.
- R9: With `dest_mem`=1, `store_data` carries the element in its low bits, with zeros above. `store_bytes` is 1, 4 or 8 for byte, doubleword or quadword, and `reg_result` is zero. With `dest_mem`=0, `store_data` and `store_bytes` are zero.
- R10: `elem_sel`=3 is reserved and raises `ud_flag`. Whenever `ud_flag` is high, `reg_result`, `store_data` and `store_bytes` are zero.
- R11: Immediate bits above the lane index used for the selected size have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Vector source operand |
| imm | input | 8 | Immediate holding the lane index |
| elem_sel | input | 2 | Element size: 0 byte, 1 doubleword, 2 quadword, 3 reserved |
| mode64 | input | 1 | 64-bit operating mode |
| dest_mem | input | 1 | 1 = memory destination, 0 = register destination |
| vec_enc | input | 1 | Request uses the vector encoding |
| w_bit | input | 1 | Width bit from the encoding |
| vlen | input | 2 | Vector-length field from the encoding |
| xreg_spec | input | 4 | Extra-register specifier from the encoding |
| out_valid | output | 1 | Result valid |
| reg_result | output | 64 | Register destination value |
| store_data | output | 64 | Memory store value in the low bits |
| store_bytes | output | 4 | Store width in bytes (0 = no store) |
| ud_flag | output | 1 | Invalid-opcode fault |

## Verification
The hardest cases to reach are the interactions between fields that are valid on their own. A doubleword select with `w_bit` set must become a quadword in 64-bit mode and stay a doubleword outside it. A legacy encoding must ignore a bad specifier, and a fault must suppress a memory store. The stimulus reaches these by repeating the same select with only `mode64`, `w_bit` or `vec_enc` changed, and by filling the unused immediate bits with ones. Each source byte is distinct, so a wrong lane or a missing mask shows up as a mismatch in the value.

// File: rtl/lx_pkg.sv
// Shared types for the lane extract unit.
package lx_pkg;
    typedef enum logic [1:0] {
        EL_BYTE  = 2'd0,
        EL_DWORD = 2'd1,
        EL_QWORD = 2'd2,
        EL_RSVD  = 2'd3
    } elem_e;
endpackage

// File: rtl/lx_fault_check.sv
// Resolves the effective element size from the select, mode and width bit,
// and raises the invalid-opcode fault from the encoding fields.
// Assumes a vector-encoded form requires an all-ones specifier and a zero length.
module lx_fault_check
    import lx_pkg::*;
#(
    parameter int SPEC_W = 4,
    parameter int VLEN_W = 2
) (
    input  logic [1:0]        elem_sel,
    input  logic              mode64,
    input  logic              w_bit,
    input  logic              vec_enc,
    input  logic [VLEN_W-1:0] vlen,
    input  logic [SPEC_W-1:0] xreg_spec,
    output elem_e             eff_size,
    output logic              fault
);
    localparam logic [SPEC_W-1:0] SPEC_OK = '1;

    // Effective size: the width bit promotes a doubleword only in 64-bit mode.
    always_comb begin
        unique case (elem_sel)
            2'd0:    eff_size = EL_BYTE;
            2'd1:    eff_size = (mode64 && w_bit) ? EL_QWORD : EL_DWORD;
            2'd2:    eff_size = EL_QWORD;
            default: eff_size = EL_RSVD;
        endcase
    end

    // Fault: quadword outside 64-bit mode, reserved size, or bad vector fields.
    always_comb begin
        fault = 1'b0;
        if (eff_size == EL_RSVD)                      fault = 1'b1;
        if (eff_size == EL_QWORD && !mode64)          fault = 1'b1;
        if (vec_enc && (xreg_spec != SPEC_OK))        fault = 1'b1;
        if (vec_enc && (vlen != '0))                  fault = 1'b1;
    end
endmodule

// File: rtl/lx_lane_mux.sv
// Splits the vector into byte, doubleword and quadword lanes and picks one
// lane of the effective size from the low immediate bits.
// Assumes little-endian lane numbering and VEC_W a multiple of 64.
module lx_lane_mux
    import lx_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int OUT_W = 64,
    parameter int IMM_W = 8
) (
    input  logic [VEC_W-1:0] src_vec,
    input  logic [IMM_W-1:0] imm,
    input  elem_e            eff_size,
    output logic [OUT_W-1:0] elem
);
    localparam int NB = VEC_W / 8;
    localparam int ND = VEC_W / 32;
    localparam int NQ = VEC_W / 64;
    localparam int BIX = $clog2(NB);
    localparam int DIX = $clog2(ND);
    localparam int QIX = (NQ > 1) ? $clog2(NQ) : 1;

    logic [7:0]  b_lane [NB];
    logic [31:0] d_lane [ND];
    logic [63:0] q_lane [NQ];

    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_b
            assign b_lane[gi] = src_vec[gi*8 +: 8];
        end
        for (gi = 0; gi < ND; gi++) begin : g_d
            assign d_lane[gi] = src_vec[gi*32 +: 32];
        end
        for (gi = 0; gi < NQ; gi++) begin : g_q
            assign q_lane[gi] = src_vec[gi*64 +: 64];
        end
    endgenerate

    logic [BIX-1:0] b_idx;
    logic [DIX-1:0] d_idx;
    logic [QIX-1:0] q_idx;
    assign b_idx = imm[BIX-1:0];
    assign d_idx = imm[DIX-1:0];
    assign q_idx = imm[QIX-1:0];

    // Lane pick: only the index bits for the size are used, the rest ignored.
    always_comb begin
        elem = '0;
        unique case (eff_size)
            EL_BYTE:  elem = OUT_W'(b_lane[b_idx]);
            EL_DWORD: elem = OUT_W'(d_lane[d_idx]);
            EL_QWORD: elem = OUT_W'(q_lane[q_idx]);
            default:  elem = '0;
        endcase
    end
endmodule

// File: rtl/lx_result_format.sv
// Formats the zero-extended element for the register or memory destination
// and suppresses both when the request faults.
// Assumes the element arrives already zero-extended in its low bits.
module lx_result_format
    import lx_pkg::*;
#(
    parameter int OUT_W = 64,
    parameter int CNT_W = 4
) (
    input  elem_e             eff_size,
    input  logic              fault,
    input  logic              dest_mem,
    input  logic              mode64,
    input  logic [OUT_W-1:0]  elem,
    output logic [OUT_W-1:0]  reg_val,
    output logic [OUT_W-1:0]  st_data,
    output logic [CNT_W-1:0]  st_bytes
);
    localparam logic [OUT_W-1:0] MASK32 = OUT_W'(32'hFFFF_FFFF);

    // Register path: zero fill to 64 bits, or to 32 bits outside 64-bit mode.
    always_comb begin
        reg_val = '0;
        if (!fault && !dest_mem)
            reg_val = mode64 ? elem : (elem & MASK32);
    end

    // Memory path: the element only, with a byte count by size.
    always_comb begin
        st_data  = '0;
        st_bytes = '0;
        if (!fault && dest_mem) begin
            st_data = elem;
            unique case (eff_size)
                EL_BYTE:  st_bytes = CNT_W'(1);
                EL_DWORD: st_bytes = CNT_W'(4);
                EL_QWORD: st_bytes = CNT_W'(8);
                default:  st_bytes = '0;
            endcase
        end
    end
endmodule

// File: rtl/lane_extract_unit.sv
// Top of the lane extract unit: combinational extract, check and format,
// followed by one register stage with a valid strobe.
// Assumes one request per cycle at most; outputs read zero when not valid.
module lane_extract_unit
    import lx_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int OUT_W  = 64,
    parameter int IMM_W  = 8,
    parameter int SPEC_W = 4,
    parameter int VLEN_W = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        elem_sel,
    input  logic              mode64,
    input  logic              dest_mem,
    input  logic              vec_enc,
    input  logic              w_bit,
    input  logic [VLEN_W-1:0] vlen,
    input  logic [SPEC_W-1:0] xreg_spec,
    output logic              out_valid,
    output logic [OUT_W-1:0]  reg_result,
    output logic [OUT_W-1:0]  store_data,
    output logic [CNT_W-1:0]  store_bytes,
    output logic              ud_flag
);
    elem_e            eff_size;
    logic             fault;
    logic [OUT_W-1:0] elem;
    logic [OUT_W-1:0] reg_val;
    logic [OUT_W-1:0] st_data;
    logic [CNT_W-1:0] st_bytes;

    lx_fault_check #(.SPEC_W(SPEC_W), .VLEN_W(VLEN_W)) u_fault (
        .elem_sel (elem_sel),
        .mode64   (mode64),
        .w_bit    (w_bit),
        .vec_enc  (vec_enc),
        .vlen     (vlen),
        .xreg_spec(xreg_spec),
        .eff_size (eff_size),
        .fault    (fault)
    );

    lx_lane_mux #(.VEC_W(VEC_W), .OUT_W(OUT_W), .IMM_W(IMM_W)) u_mux (
        .src_vec (src_vec),
        .imm     (imm),
        .eff_size(eff_size),
        .elem    (elem)
    );

    lx_result_format #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_fmt (
        .eff_size(eff_size),
        .fault   (fault),
        .dest_mem(dest_mem),
        .mode64  (mode64),
        .elem    (elem),
        .reg_val (reg_val),
        .st_data (st_data),
        .st_bytes(st_bytes)
    );

    // Output stage: capture a valid request, clear everything otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid   <= 1'b0;
            reg_result  <= '0;
            store_data  <= '0;
            store_bytes <= '0;
            ud_flag     <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            reg_result  <= reg_val;
            store_data  <= st_data;
            store_bytes <= st_bytes;
            ud_flag     <= fault;
        end
    end
endmodule

// File: rtl/lx_checker.sv
// Protocol and fault properties of the lane extract unit, bound to the top.
module lx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  elem_sel,
    input logic        mode64,
    input logic        vec_enc,
    input logic [1:0]  vlen,
    input logic [3:0]  xreg_spec,
    input logic        out_valid,
    input logic [63:0] reg_result,
    input logic [63:0] store_data,
    input logic [3:0]  store_bytes,
    input logic        ud_flag
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (reg_result == 0 && store_bytes == 0 && !ud_flag));
    a_r7_qword_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_sel == 2'd2 && !mode64) |=> ud_flag);
    a_r8_vec_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_enc && (xreg_spec != 4'hF || vlen != 2'd0)) |=> ud_flag);
    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ud_flag |-> (reg_result == 0 && store_data == 0 && store_bytes == 0));
    a_r9_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (store_bytes != 0) |-> (reg_result == 0));
    a_r9_byte_store: assert property (@(posedge clk) disable iff (!rst_n)
        (store_bytes == 4'd1) |-> (store_data[63:8] == 0));
endmodule

bind lane_extract_unit lx_checker u_lx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .elem_sel   (elem_sel),
    .mode64     (mode64),
    .vec_enc    (vec_enc),
    .vlen       (vlen),
    .xreg_spec  (xreg_spec),
    .out_valid  (out_valid),
    .reg_result (reg_result),
    .store_data (store_data),
    .store_bytes(store_bytes),
    .ud_flag    (ud_flag)
);

// File: tb/sim_lane_extract_unit.sv
`timescale 1ns/1ps
module sim_lane_extract_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0;
    logic [7:0]   imm = '0;
    logic [1:0]   elem_sel = '0;
    logic         mode64 = 1'b0;
    logic         dest_mem = 1'b0;
    logic         vec_enc = 1'b0;
    logic         w_bit = 1'b0;
    logic [1:0]   vlen = '0;
    logic [3:0]   xreg_spec = '0;
    logic         out_valid;
    logic [63:0]  reg_result;
    logic [63:0]  store_data;
    logic [3:0]   store_bytes;
    logic         ud_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lane_extract_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .imm(imm), .elem_sel(elem_sel), .mode64(mode64), .dest_mem(dest_mem),
        .vec_enc(vec_enc), .w_bit(w_bit), .vlen(vlen), .xreg_spec(xreg_spec),
        .out_valid(out_valid), .reg_result(reg_result), .store_data(store_data),
        .store_bytes(store_bytes), .ud_flag(ud_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] byte_at(input int k);
        return {56'd0, src_vec[k*8 +: 8]};
    endfunction
    function automatic logic [63:0] dword_at(input int k);
        return {32'd0, src_vec[k*32 +: 32]};
    endfunction
    function automatic logic [63:0] qword_at(input int k);
        return src_vec[k*64 +: 64];
    endfunction

    // Drive one request at a falling edge, sample the result one clock later.
    task automatic run(input logic [1:0] sel, input logic m64, input logic mem,
                       input logic ve, input logic w, input logic [1:0] vl,
                       input logic [3:0] xr, input logic [7:0] im);
        @(negedge clk);
        in_valid = 1'b1; elem_sel = sel; mode64 = m64; dest_mem = mem;
        vec_enc = ve; w_bit = w; vlen = vl; xreg_spec = xr; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R1 reset result", reg_result, 64'd0);
        chk("R1 reset ud", {63'd0, ud_flag}, 64'd0);
    endtask

    task automatic t_byte();
        for (int k = 0; k < 16; k += 5) begin
            run(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 8'hF0 | 8'(k));
            chk("R2 R5 R11 byte lane", reg_result, byte_at(k));
            chk("R9 reg dest no store", {60'd0, store_bytes}, 64'd0);
        end
    endtask

    task automatic t_dword();
        for (int k = 0; k < 4; k++) begin
            run(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'hF, {6'b101011, 2'(k)});
            chk("R3 R11 dword lane", reg_result, dword_at(k));
            chk("R3 no fault", {63'd0, ud_flag}, 64'd0);
        end
    endtask

    task automatic t_qword();
        for (int k = 0; k < 2; k++) begin
            run(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, {7'b1111111, 1'(k)});
            chk("R4 R11 qword lane", reg_result, qword_at(k));
        end
        run(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 8'h03);
        chk("R4 promoted by w", reg_result, qword_at(1));
    endtask

    task automatic t_legacy_mode();
        run(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 8'h03);
        chk("R5 R6 w ignored in 32-bit mode", reg_result, dword_at(3));
        chk("R5 no fault", {63'd0, ud_flag}, 64'd0);
        run(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 8'h0E);
        chk("R6 byte zero fill", reg_result, byte_at(14));
        run(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 8'h01);
        chk("R7 qword fault", {63'd0, ud_flag}, 64'd1);
        chk("R10 fault result zero", reg_result, 64'd0);
    endtask

    task automatic t_vec_fields();
        run(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'hE, 8'h01);
        chk("R8 bad specifier", {63'd0, ud_flag}, 64'd1);
        run(2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 4'hF, 8'h01);
        chk("R8 bad length", {63'd0, ud_flag}, 64'd1);
        run(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 4'h0, 8'h07);
        chk("R8 legacy ignores fields", {63'd0, ud_flag}, 64'd0);
        chk("R8 legacy result", reg_result, byte_at(7));
        run(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 8'h00);
        chk("R10 reserved size", {63'd0, ud_flag}, 64'd1);
    endtask

    task automatic t_mem();
        run(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'h0, 8'h03);
        chk("R9 byte store data", store_data, byte_at(3));
        chk("R9 byte store width", {60'd0, store_bytes}, 64'd1);
        chk("R9 reg zero on store", reg_result, 64'd0);
        run(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'h0, 8'h02);
        chk("R9 dword store data", store_data, dword_at(2));
        chk("R9 dword store width", {60'd0, store_bytes}, 64'd4);
        run(2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'h0, 8'h01);
        chk("R9 qword store data", store_data, qword_at(1));
        chk("R9 qword store width", {60'd0, store_bytes}, 64'd8);
        run(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'h0, 8'h01);
        chk("R10 fault no store", {60'd0, store_bytes}, 64'd0);
        chk("R10 fault no data", store_data, 64'd0);
    endtask

    task automatic t_idle();
        run(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 8'h09);
        @(negedge clk);
        chk("R1 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R1 idle result", reg_result, 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) src_vec[i*8 +: 8] = 8'(8'h81 + i * 8'h13);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_byte();
        t_dword();
        t_qword();
        t_legacy_mode();
        t_vec_fields();
        t_mem();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule